// File: doc/BRIEF.md
# Dataflow Operand Matching Store

This block pairs operands for a dataflow processor ring. Result tokens arrive carrying a data word, the address of the instruction that consumes the word, and a flag naming which of the two source fields of that instruction the word fills. The store keeps the first operand that arrives for an instruction. When the partner operand arrives, it emits both operands as a pair. The pair goes to the stream that owns the instruction, where the stream merges it with the opcode and destinations that were fixed when the program was loaded.

Matching uses plain directly indexed memory. Each instruction has one slot for each source side, and each slot has a presence bit. No tag or label is compared. The destination address is split into a stream number and an instruction index. A load port clears the presence bits of one instruction per cycle while a program is loaded. A slot that is never loaded with a token, such as a null instruction, never produces a pair. A token that lands on a slot that is already occupied raises a sticky error flag.

Top module: `operand_match_store`

## Requirements
- R1: After reset, `pair_valid_o` and `err_overwrite_o` are 0, `tok_ready_o` is 1, and every presence bit is clear.
- R2: A token accepted for an instruction with no operand present on the other side is stored. No pair is emitted.
- R3: A token accepted for an instruction whose other side is present raises `pair_valid_o` on the following clock edge. The pair carries the following fields:
  - `pair_src1_o` holds the side-0 operand and `pair_src2_o` holds the side-1 operand.
  - `pair_stream_o` holds the upper `STREAM_W` bits of `tok_addr_i`.
  - `pair_idx_o` holds the lower `IDX_W` bits of `tok_addr_i`.
- R4: A match clears both presence bits of that instruction. A later single token for the same instruction therefore emits no pair.
- R5: Tokens match only when their full address is equal. The same index in two different streams forms two independent instructions.
- R6: A token for a side whose presence bit is already set has the following effects:
  - `err_overwrite_o` is set and stays set until reset.
  - The token replaces the stored value.
  - No pair is emitted.
- R7: While `pair_valid_o` is 1, `tok_ready_o` is 0. While `pair_ready_i` is 0, the pair fields hold steady. The pair drops one edge after `pair_ready_i` is seen high.
- R8: When `ld_clr_i` is high, `tok_ready_o` is 0. The presence bits of instruction `ld_addr_i` are cleared on that edge.
- R9: Arrival order does not matter. Side 1 arriving before side 0 yields the same pair field placement as the reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tok_valid_i | input | 1 | Incoming token valid |
| tok_ready_o | output | 1 | Store can accept a token this cycle |
| tok_addr_i | input | STREAM_W+IDX_W | Destination instruction: {stream, index} |
| tok_side_i | input | 1 | Source field: 0 = source 1, 1 = source 2 |
| tok_data_i | input | DATA_W | Operand value |
| ld_clr_i | input | 1 | Load port: clear presence of one instruction |
| ld_addr_i | input | STREAM_W+IDX_W | Instruction cleared by the load port |
| pair_valid_o | output | 1 | Primed operand pair valid |
| pair_ready_i | input | 1 | Consumer takes the pair |
| pair_stream_o | output | STREAM_W | Owning stream of the pair |
| pair_idx_o | output | IDX_W | Instruction index within the stream |
| pair_src1_o | output | DATA_W | Source 1 operand |
| pair_src2_o | output | DATA_W | Source 2 operand |
| err_overwrite_o | output | 1 | Sticky overwrite error |

## Verification
The bench builds the block with its default parameters: 16-bit data, 2 stream bits and 4 index bits, for 64 instructions.

Random tokens are confined to a handful of addresses. These include index 5 in three different streams and the last slot of the last stream. This brings frequent matches, same-side overwrites and cross-stream aliasing within reach in a few hundred tokens.

Directed sequences cover both arrival orders, a held output under back-pressure, and load clears of a half-filled instruction.

// File: rtl/mstore_pkg.sv
`timescale 1ns/1ps
package mstore_pkg;
  typedef enum logic {
    SIDE_SRC1 = 1'b0,
    SIDE_SRC2 = 1'b1
  } side_e;
endpackage

// File: rtl/mstore_addr_split.sv
`timescale 1ns/1ps
module mstore_addr_split #(
  parameter int STREAM_W = 2,
  parameter int IDX_W    = 4
) (
  input  logic [STREAM_W+IDX_W-1:0] addr_i,
  output logic [STREAM_W-1:0]       stream_o,
  output logic [IDX_W-1:0]          idx_o
);
  assign stream_o = addr_i[STREAM_W+IDX_W-1:IDX_W];
  assign idx_o    = addr_i[IDX_W-1:0];
endmodule

// File: rtl/mstore_side_bank.sv
`timescale 1ns/1ps
module mstore_side_bank #(
  parameter int DATA_W = 16,
  parameter int AW     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic              set_i,
  input  logic [DATA_W-1:0] set_data_i,
  input  logic              clr_i,
  input  logic [AW-1:0]     clr_addr_i,
  output logic              present_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0]  pres_q;
  logic [DATA_W-1:0] mem_q [DEPTH];

  // set and clear never target the same slot in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_q <= '0;
    end else begin
      if (clr_i) pres_q[clr_addr_i] <= 1'b0;
      if (set_i) pres_q[rd_addr_i]  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (set_i) mem_q[rd_addr_i] <= set_data_i;
  end

  assign present_o = pres_q[rd_addr_i];
  assign data_o    = mem_q[rd_addr_i];
endmodule

// File: rtl/mstore_out_reg.sv
`timescale 1ns/1ps
module mstore_out_reg #(
  parameter int W = 38
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= load_data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/operand_match_store.sv
`timescale 1ns/1ps
module operand_match_store
  import mstore_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int STREAM_W = 2,
  parameter int IDX_W    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tok_valid_i,
  output logic                      tok_ready_o,
  input  logic [STREAM_W+IDX_W-1:0] tok_addr_i,
  input  logic                      tok_side_i,
  input  logic [DATA_W-1:0]         tok_data_i,
  input  logic                      ld_clr_i,
  input  logic [STREAM_W+IDX_W-1:0] ld_addr_i,
  output logic                      pair_valid_o,
  input  logic                      pair_ready_i,
  output logic [STREAM_W-1:0]       pair_stream_o,
  output logic [IDX_W-1:0]          pair_idx_o,
  output logic [DATA_W-1:0]         pair_src1_o,
  output logic [DATA_W-1:0]         pair_src2_o,
  output logic                      err_overwrite_o
);
  localparam int AW    = STREAM_W + IDX_W;
  localparam int PAIRW = STREAM_W + IDX_W + 2 * DATA_W;

  side_e             side;
  logic              accept, hit, dup;
  logic              present [2];
  logic [DATA_W-1:0] bdata   [2];
  logic [STREAM_W-1:0] tok_stream;
  logic [IDX_W-1:0]    tok_idx;
  logic [AW-1:0]       clr_addr;
  logic [DATA_W-1:0]   src1, src2;
  logic [PAIRW-1:0]    pair_d, pair_q;

  assign side        = side_e'(tok_side_i);
  assign tok_ready_o = !pair_valid_o && !ld_clr_i;
  assign accept      = tok_valid_i && tok_ready_o;
  assign hit         = accept && present[~tok_side_i];
  assign dup         = accept && present[tok_side_i];
  assign clr_addr    = ld_clr_i ? ld_addr_i : tok_addr_i;

  mstore_addr_split #(.STREAM_W(STREAM_W), .IDX_W(IDX_W)) u_split (
    .addr_i   (tok_addr_i),
    .stream_o (tok_stream),
    .idx_o    (tok_idx)
  );

  for (genvar s = 0; s < 2; s++) begin : g_bank
    logic set_s;
    assign set_s = accept && !hit && (tok_side_i == 1'(s));
    mstore_side_bank #(.DATA_W(DATA_W), .AW(AW)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_addr_i  (tok_addr_i),
      .set_i      (set_s),
      .set_data_i (tok_data_i),
      .clr_i      (hit || ld_clr_i),
      .clr_addr_i (clr_addr),
      .present_o  (present[s]),
      .data_o     (bdata[s])
    );
  end

  // incoming operand bypasses its own bank into the pair
  assign src1   = (side == SIDE_SRC1) ? tok_data_i : bdata[0];
  assign src2   = (side == SIDE_SRC2) ? tok_data_i : bdata[1];
  assign pair_d = {tok_stream, tok_idx, src1, src2};

  mstore_out_reg #(.W(PAIRW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (hit),
    .load_data_i (pair_d),
    .ready_i     (pair_ready_i),
    .valid_o     (pair_valid_o),
    .data_o      (pair_q)
  );

  assign {pair_stream_o, pair_idx_o, pair_src1_o, pair_src2_o} = pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  err_overwrite_o <= 1'b0;
    else if (dup) err_overwrite_o <= 1'b1;
  end
endmodule

// File: rtl/mstore_checker.sv
`timescale 1ns/1ps
module mstore_checker #(
  parameter int DATA_W   = 16,
  parameter int STREAM_W = 2,
  parameter int IDX_W    = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      tok_valid_i,
  input logic                      tok_ready_o,
  input logic                      ld_clr_i,
  input logic                      pair_valid_o,
  input logic                      pair_ready_i,
  input logic [STREAM_W-1:0]       pair_stream_o,
  input logic [IDX_W-1:0]          pair_idx_o,
  input logic [DATA_W-1:0]         pair_src1_o,
  input logic [DATA_W-1:0]         pair_src2_o,
  input logic                      err_overwrite_o
);
  assert_block_when_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> !tok_ready_o);

  assert_pair_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && !pair_ready_i) |=> (pair_valid_o && $stable(pair_src1_o) &&
      $stable(pair_src2_o) && $stable(pair_stream_o) && $stable(pair_idx_o)));

  assert_pair_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_valid_o && pair_ready_i) |=> !pair_valid_o);

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_overwrite_o |=> err_overwrite_o);

  assert_load_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_clr_i |-> !tok_ready_o);

  assert_pair_from_token_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pair_valid_o) |-> $past(tok_valid_i && tok_ready_o));
endmodule

bind operand_match_store mstore_checker #(
  .DATA_W(DATA_W), .STREAM_W(STREAM_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .tok_valid_i     (tok_valid_i),
  .tok_ready_o     (tok_ready_o),
  .ld_clr_i        (ld_clr_i),
  .pair_valid_o    (pair_valid_o),
  .pair_ready_i    (pair_ready_i),
  .pair_stream_o   (pair_stream_o),
  .pair_idx_o      (pair_idx_o),
  .pair_src1_o     (pair_src1_o),
  .pair_src2_o     (pair_src2_o),
  .err_overwrite_o (err_overwrite_o)
);

// File: tb/sim_operand_match_store.sv
`timescale 1ns/1ps
module sim_operand_match_store;
  localparam int DW = 16, SW = 2, IW = 4, AW = SW + IW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tok_valid = 1'b0, tok_side = 1'b0, ld_clr = 1'b0, pair_ready = 1'b0;
  logic [AW-1:0] tok_addr = '0, ld_addr = '0;
  logic [DW-1:0] tok_data = '0;
  logic tok_ready, pair_valid, err;
  logic [SW-1:0] pair_stream;
  logic [IW-1:0] pair_idx;
  logic [DW-1:0] pair_src1, pair_src2;

  int n_chk = 0, n_bad = 0;
  bit            m_pres [2][DEPTH];
  logic [DW-1:0] m_val  [2][DEPTH];
  bit            m_err = 0;

  always #4 clk = ~clk;

  operand_match_store #(.DATA_W(DW), .STREAM_W(SW), .IDX_W(IW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tok_valid_i(tok_valid), .tok_ready_o(tok_ready),
    .tok_addr_i(tok_addr), .tok_side_i(tok_side), .tok_data_i(tok_data),
    .ld_clr_i(ld_clr), .ld_addr_i(ld_addr), .pair_valid_o(pair_valid),
    .pair_ready_i(pair_ready), .pair_stream_o(pair_stream), .pair_idx_o(pair_idx),
    .pair_src1_o(pair_src1), .pair_src2_o(pair_src2), .err_overwrite_o(err));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pick(input bit s, input logic [DW-1:0] d, input bit own, input logic [AW-1:0] a);
    return (s == own) ? d : m_val[s][a];
  endfunction

  // drive one token, check outcome, drain any pair
  task automatic send(input logic [AW-1:0] a, input bit s, input logic [DW-1:0] d, input bit hold);
    bit            exp_hit;
    logic [DW-1:0] e1, e2;
    exp_hit = m_pres[!s][a];
    e1 = pick(1'b0, d, s, a);
    e2 = pick(1'b1, d, s, a);
    if (exp_hit) begin
      m_pres[0][a] = 0; m_pres[1][a] = 0;
    end else begin
      if (m_pres[s][a]) m_err = 1;
      m_pres[s][a] = 1; m_val[s][a] = d;
    end
    @(negedge clk);
    tok_valid = 1; tok_addr = a; tok_side = s; tok_data = d;
    #1 chk(tok_ready == 1'b1, "R7 ready idle", 64'(tok_ready), 1);
    @(negedge clk);
    tok_valid = 0;
    #1;
    chk(pair_valid == exp_hit, exp_hit ? "R3 pair raised" : "R2 R4 R5 no pair", 64'(pair_valid), 64'(exp_hit));
    chk(err == m_err, "R6 overwrite flag", 64'(err), 64'(m_err));
    if (exp_hit) begin
      chk(pair_src1 == e1, "R3 R9 src1", 64'(pair_src1), 64'(e1));
      chk(pair_src2 == e2, "R3 R9 src2", 64'(pair_src2), 64'(e2));
      chk({pair_stream, pair_idx} == a, "R3 stream idx", 64'({pair_stream, pair_idx}), 64'(a));
      chk(tok_ready == 1'b0, "R7 blocked while full", 64'(tok_ready), 0);
      if (hold) begin
        @(negedge clk); #1;
        chk(pair_valid && pair_src1 == e1 && pair_src2 == e2, "R7 held",
            64'({pair_valid, pair_src1}), 64'({1'b1, e1}));
      end
      pair_ready = 1;
      @(negedge clk);
      pair_ready = 0;
      #1 chk(pair_valid == 1'b0, "R7 drained", 64'(pair_valid), 0);
    end
  endtask

  task automatic load_clear(input logic [AW-1:0] a);
    @(negedge clk);
    ld_clr = 1; ld_addr = a;
    #1 chk(tok_ready == 1'b0, "R8 load blocks tokens", 64'(tok_ready), 0);
    @(negedge clk);
    ld_clr = 0;
    m_pres[0][a] = 0; m_pres[1][a] = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [AW-1:0] pool [6];
    seed = $urandom(32'h5eed);
    pool[0] = 6'h05; pool[1] = 6'h15; pool[2] = 6'h25; pool[3] = 6'h3f;
    pool[4] = 6'h00; pool[5] = 6'h0a;
    for (int i = 0; i < DEPTH; i++) begin
      m_pres[0][i] = 0; m_pres[1][i] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(pair_valid == 0, "R1 reset pair", 64'(pair_valid), 0);
    chk(err == 0, "R1 reset err", 64'(err), 0);
    chk(tok_ready == 1, "R1 reset ready", 64'(tok_ready), 1);
    rst_ni = 1;

    send(6'h05, 0, 16'h1111, 0);      // R2
    send(6'h05, 1, 16'h2222, 1);      // R3 with hold R7
    send(6'h05, 1, 16'h3333, 0);      // R4 cleared after match
    send(6'h15, 0, 16'h4444, 0);      // R5 other stream, same index
    send(6'h25, 0, 16'h5555, 0);      // R5 no match across streams
    send(6'h15, 1, 16'h6666, 0);      // R9 reversed order on 0x05 next
    send(6'h05, 0, 16'h7777, 0);      // R9 completes side1-first
    send(6'h3f, 1, 16'h8888, 0);
    load_clear(6'h3f);                // R8
    send(6'h3f, 0, 16'h9999, 0);      // R8 no pair after clear
    send(6'h0a, 1, 16'haaaa, 0);
    send(6'h0a, 1, 16'hbbbb, 0);      // R6 overwrite
    send(6'h0a, 0, 16'hcccc, 1);      // R6 replaced value emitted
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom();
      if (r[7:0] < 8) load_clear(pool[r[10:8] % 6]);
      else send(pool[r[10:8] % 6], r[11], DW'($urandom()), r[12]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule